// File: doc/BRIEF.md
# Bidirectional Latched Serial-to-Parallel Driver

This block turns a serial bit stream into 64 parallel control levels for a bank of output drivers. A 64-bit shift register advances on every rising edge of the shift clock. A direction input selects which end of the register takes in new data. Two bidirectional serial pins swap roles with the direction. The pin at the input end is released, and the pin at the far end drives the bit that falls off the register. Several devices can therefore share one stream, each passing its overflow to the next.

A storage stage sits behind the register. While the latch enable is high, it passes the register contents to the outputs within the same cycle. When the enable drops, it keeps the last value. Polarity inversion and a blanking gate act on that stored word only. Neither touches the shift path.

Top module: `sp_driver_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears the shift register and the stored word to zero. With `polKeep`=1 and `blankN`=1, every `drvOut` bit and the serial data-out pin then read 0.
- R2: With `dir`=0, `serA` is the data input. Each rising edge moves every bit from index k to index k-1 and loads `serA` into index 63 (output 64). `serB` shows index 0. The first of 64 bits fed therefore ends at `drvOut[0]`.
- R3: With `dir`=1, `serB` is the data input. Each rising edge moves every bit from index k to index k+1 and loads `serB` into index 0 (output 1). `serA` shows index 63. The first of 64 bits fed therefore ends at `drvOut[63]`.
- R4: Only the data-out pin is driven. The data-in pin stays high-impedance, so the external source on it is the only driver of that net.
- R5: While `latchEn` is high, the stored word follows the shift register, and a new register value appears on `drvOut` with no added cycle. Raising `latchEn` shows the current register contents at once.
- R6: While `latchEn` is low, `drvOut` keeps the value present when the enable fell, whatever is shifted in.
- R7: `polKeep`=1 passes the stored word to `drvOut` unchanged. `polKeep`=0 inverts all 64 bits.
- R8: `blankN`=0 forces every `drvOut` bit to 0, whatever `polKeep` is set to. Releasing it restores the stored word, which blanking leaves intact.
- R9: Two devices can be chained through their serial pins in either direction. After 128 shifts, each device holds its own 64-bit word.
- R10: The serial data-out stream is the same whatever `latchEn`, `polKeep` and `blankN` are set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dir | input | 1 | Shift direction: 0 toward index 0, 1 toward index 63 |
| latchEn | input | 1 | Latch enable: high is transparent, low holds |
| polKeep | input | 1 | Polarity select: 1 passes, 0 inverts |
| blankN | input | 1 | Active-low blanking of all outputs |
| serA | inout | 1 | Serial pin A: data input when dir=0, data output when dir=1 |
| serB | inout | 1 | Serial pin B: data output when dir=0, data input when dir=1 |
| drvOut | output | 64 | Parallel driver levels |

## Verification
A fault in the shift register shows at the data-out pin within 64 shifts. With the latch open, it also shows on `drvOut` in the same cycle. A hold register that loads when it should not surfaces on `drvOut` as soon as the latch closes and new data is shifted in. One that fails to load appears on the first cycle the latch is open. A direction decoding fault appears at once: both serial nets would be driven, or one would float. It also shows as a reversed word after one full load. Polarity and blanking faults appear on `drvOut` combinationally, in the cycle the inputs change.

// File: rtl/spdrv_pkg.sv
package spdrv_pkg;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic dirUp;        // 1: shift toward the high index
    logic loadHold;     // update the hold register at this edge
    logic transparent;  // outputs view the live shift register
    logic invert;       // invert the stored word on the outputs
    logic blank;        // force all outputs low
    logic serIn;        // serial bit entering the register
  } spdrvStrobe_t;

endpackage

// File: rtl/sp_driver_ctrl.sv
module sp_driver_ctrl
  import spdrv_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         dir,
  input  logic         latchEn,
  input  logic         polKeep,
  input  logic         blankN,
  input  logic         serAIn,
  input  logic         serBIn,
  output spdrvStrobe_t stb,
  output logic         oeA,
  output logic         oeB
);

  always_comb begin
    stb.dirUp       = dir;
    stb.loadHold    = latchEn;
    stb.transparent = latchEn;
    stb.invert      = ~polKeep;
    stb.blank       = ~blankN;
    stb.serIn       = dir ? serBIn : serAIn;
    oeA             = dir;
    oeB             = ~dir;
  end

  // Exactly one serial pin is driven at any time
  assert_oe_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot({oeA, oeB}));

  // The driven pin is the far end of the chosen direction
  assert_oe_matches_dir_R4: assert property (@(posedge clk) disable iff (rst)
    (stb.dirUp |-> oeA) and (!stb.dirUp |-> oeB));

endmodule

// File: rtl/sp_driver_path.sv
module sp_driver_path
  import spdrv_pkg::*;
#(
  parameter int CHANNELS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  spdrvStrobe_t        stb,
  output logic [CHANNELS-1:0] drvOut,
  output logic                farBit
);

  localparam int LAST = CHANNELS - 1;

  logic [LAST:0] shiftQ;
  logic [LAST:0] shiftNext;
  logic [LAST:0] holdQ;
  logic [LAST:0] viewQ;

  always_comb begin
    if (stb.dirUp) shiftNext = {shiftQ[LAST-1:0], stb.serIn};
    else           shiftNext = {stb.serIn, shiftQ[LAST:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ <= '0;
      holdQ  <= '0;
    end else begin
      shiftQ <= shiftNext;
      if (stb.loadHold) holdQ <= shiftNext;
    end
  end

  assign viewQ  = stb.transparent ? shiftQ : holdQ;
  assign farBit = stb.dirUp ? shiftQ[LAST] : shiftQ[0];

  // Per-channel polarity and blanking gate
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_gate
    always_comb begin
      if (stb.blank) drvOut[ch] = 1'b0;
      else           drvOut[ch] = viewQ[ch] ^ stb.invert;
    end
  end

  assert_shift_down_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(stb.dirUp)) |->
      (shiftQ[LAST] == $past(stb.serIn) && shiftQ[LAST-1:0] == $past(shiftQ[LAST:1])));

  assert_shift_up_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stb.dirUp)) |->
      (shiftQ[0] == $past(stb.serIn) && shiftQ[LAST:1] == $past(shiftQ[LAST-1:0])));

  assert_hold_tracks_R5: assert property (@(posedge clk) disable iff (rst)
    stb.loadHold |=> (holdQ == shiftQ));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !stb.loadHold |=> $stable(holdQ));

  assert_blank_zero_R8: assert property (@(posedge clk) disable iff (rst)
    stb.blank |-> (drvOut == '0));

endmodule

// File: rtl/sp_driver_bank.sv
module sp_driver_bank
  import spdrv_pkg::*;
#(
  parameter int CHANNELS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dir,
  input  logic                latchEn,
  input  logic                polKeep,
  input  logic                blankN,
  inout  wire                 serA,
  inout  wire                 serB,
  output logic [CHANNELS-1:0] drvOut
);

  spdrvStrobe_t stb;
  logic         oeA;
  logic         oeB;
  logic         farBit;

  sp_driver_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .dir     (dir),
    .latchEn (latchEn),
    .polKeep (polKeep),
    .blankN  (blankN),
    .serAIn  (serA),
    .serBIn  (serB),
    .stb     (stb),
    .oeA     (oeA),
    .oeB     (oeB)
  );

  sp_driver_path #(.CHANNELS(CHANNELS)) u_path (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .drvOut (drvOut),
    .farBit (farBit)
  );

  assign serA = oeA ? farBit : 1'bz;
  assign serB = oeB ? farBit : 1'bz;

endmodule

// File: tb/sp_driver_bank_tb.sv
module sp_driver_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir = 1'b0;
  logic latchEn = 1'b1;
  logic polKeep = 1'b1;
  logic blankN = 1'b1;
  logic tbBit = 1'b0;

  wire netA;
  wire netMid;
  wire netB;
  logic [NCH-1:0] outOne;
  logic [NCH-1:0] outTwo;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // The bench drives only the chain end that is a data input
  assign netA = (!dir) ? tbBit : 1'bz;
  assign netB = dir ? tbBit : 1'bz;

  sp_driver_bank u_dut (
    .clk(clk), .rst(rst), .dir(dir), .latchEn(latchEn), .polKeep(polKeep),
    .blankN(blankN), .serA(netA), .serB(netMid), .drvOut(outOne)
  );

  sp_driver_bank u_dut2 (
    .clk(clk), .rst(rst), .dir(dir), .latchEn(latchEn), .polKeep(polKeep),
    .blankN(blankN), .serA(netMid), .serB(netB), .drvOut(outTwo)
  );

  localparam logic [63:0] PAT  = 64'hF0F0_1234_8000_0001;
  localparam logic [63:0] PATN = 64'h0F0F_EDCB_7FFF_FFFE;

  // {polKeep, blankN, expected drvOut} applied to a held PAT (R7, R8)
  localparam logic [65:0] POL_VEC [6] = '{
    {1'b1, 1'b1, PAT},
    {1'b0, 1'b1, PATN},
    {1'b0, 1'b0, 64'h0},
    {1'b1, 1'b0, 64'h0},
    {1'b0, 1'b1, PATN},
    {1'b1, 1'b1, PAT}
  };

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic feedBit(input logic b);
    tbBit = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadWord(input logic [63:0] w);
    for (int i = 0; i < NCH; i++) feedBit(dir ? w[NCH-1-i] : w[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check64("R1 reset dev1", outOne, 64'h0);
    check64("R1 reset dev2", outTwo, 64'h0);
    check1("R1 reset serial out", netMid, 1'b0);

    // Table walk over polarity and blanking (R7, R8)
    loadWord(PAT);
    latchEn = 1'b0;
    #1;
    for (int v = 0; v < 6; v++) begin
      polKeep = POL_VEC[v][65];
      blankN  = POL_VEC[v][64];
      #1;
      check64($sformatf("R7/R8 vector %0d", v), outOne, POL_VEC[v][63:0]);
    end
    polKeep = 1'b1;
    blankN = 1'b1;
    latchEn = 1'b1;

    // R2: downward shift, A in, B out
    dir = 1'b0;
    loadWord(64'hA5C3_0F1E_7700_9B2D);
    check64("R2/R5 dir0 word", outOne, 64'hA5C3_0F1E_7700_9B2D);
    check1("R2 serB shows index0", netMid, 1'b1);
    feedBit(1'b0);
    check64("R5 follows shift", outOne, {1'b0, 64'hA5C3_0F1E_7700_9B2D >> 1});
    check1("R2 next bit out", netMid, 1'b0);

    // R3: upward shift, B in, A out (dev2 is first in chain)
    dir = 1'b1;
    loadWord(64'h1357_9BDF_2468_ACE0);
    check64("R3 dir1 word", outTwo, 64'h1357_9BDF_2468_ACE0);
    check1("R3 serA shows index63", netMid, 1'b0);
    feedBit(1'b1);
    check64("R3 shifted up", outTwo, {64'h1357_9BDF_2468_ACE0 << 1} | 64'h1);
    check1("R3 next bit out R4", netMid, 1'b0);

    // R9: cascade downward then upward
    dir = 1'b0;
    loadWord(64'hDEAD_BEEF_0123_4567);
    loadWord(64'h8899_AABB_CCDD_EEFF);
    check64("R9 dir0 dev1", outOne, 64'h8899_AABB_CCDD_EEFF);
    check64("R9 dir0 dev2", outTwo, 64'hDEAD_BEEF_0123_4567);
    check1("R9 dir0 chain out R4", netB, 1'b1);
    dir = 1'b1;
    loadWord(64'h0F00_0000_0000_00F1);
    loadWord(64'h7654_3210_FEDC_BA98);
    check64("R9 dir1 dev1", outOne, 64'h0F00_0000_0000_00F1);
    check64("R9 dir1 dev2", outTwo, 64'h7654_3210_FEDC_BA98);
    check1("R9 dir1 chain out R4", netA, 1'b0);

    // R6: hold while shifting
    dir = 1'b0;
    loadWord(PAT);
    latchEn = 1'b0;
    #1;
    check64("R6 held at fall", outOne, PAT);
    loadWord(PATN);
    check64("R6 hold during shift", outOne, PAT);
    check1("R6 shifting continued", netMid, PATN[0]);
    latchEn = 1'b1;
    #1;
    check64("R5 open shows live", outOne, PATN);

    // R10: shift path independent of latch, polarity, blank
    latchEn = 1'b0;
    polKeep = 1'b0;
    blankN = 1'b0;
    loadWord(64'h3C3C_5A5A_0000_FFFF);
    check1("R10 serial out bit0", netMid, 1'b1);
    check64("R10 blanked", outOne, 64'h0);
    latchEn = 1'b1;
    polKeep = 1'b1;
    blankN = 1'b1;
    #1;
    check64("R10 contents intact", outOne, 64'h3C3C_5A5A_0000_FFFF);

    // R1: reset during operation
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    latchEn = 1'b0;
    #1;
    check64("R1 hold cleared", outOne, 64'h0);
    latchEn = 1'b1;
    #1;
    check64("R1 shift cleared", outTwo, 64'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule